// File: doc/BRIEF.md
# Crosswise 4-bit Multiply / Add / Subtract Unit

This block is a purely combinational arithmetic unit for two unsigned 4-bit operands. In multiply mode it forms the 8-bit product. It does this by ANDing every bit of one operand with every bit of the other, sorting the sixteen terms into seven weight columns, and summing those columns from the least significant upward. Each column passes its carry to the column above it.

The four lowest columns of that column adder have a second input source. In add or subtract mode they take the operand bits instead of the partial-product terms, and so form a ripple adder. For subtraction, operand B is inverted and a one is fed into the lowest column. The carry leaving the fourth column is the add carry, or the inverted borrow.

The unit holds no state. It can sit inside a pipeline stage of a datapath, and its outputs follow its inputs within the same cycle.

Top module: `xw_arith4`

## Requirements
- R1: The operation select is decoded as 2'b00 = multiply, 2'b01 = add, 2'b10 = subtract and 2'b11 = multiply.
- R2: In multiply mode, result[7:0] equals the unsigned product A*B, for every one of the 256 operand pairs.
- R3: In multiply mode, result bit 0 equals A[0] AND B[0].
- R4: In multiply mode, the carry flag is 0.
- R5: In add mode, result[3:0] equals (A+B) mod 16 and result[4] is the carry out of the 4-bit sum.
- R6: In subtract mode, result[3:0] equals (A-B) mod 16 and result[4] is 1 exactly when A >= B (inverted borrow).
- R7: In add and subtract modes, result[7:5] is zero and the carry flag equals result[4].
- R8: The unit has no storage, so a change of operands or select appears on the outputs in the same cycle.
- R9: The carry leaving the top weight column lands in result bit 7, so 15*15 gives 8'd225 and every product with bit 7 set comes out right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | Operand A, unsigned |
| opnd_b | input | 4 | Operand B, unsigned |
| op_sel | input | 2 | Operation select (00/11 multiply, 01 add, 10 subtract) |
| result | output | 8 | Product, or the {carry, sum/difference} zero-extended |
| carry_flag | output | 1 | Add carry or subtract inverted borrow; 0 in multiply |

## Verification
The bench sweeps all 256 operand pairs in each of the four select codes. This covers both multiply codes, and catches a decoder that lets 2'b11 fall into an arithmetic mode.

The sweep includes the pairs whose product sets bit 7. A tree that drops the final column carry would return 225-128 for 15*15.

It also includes the subtract pairs with A < B and A == B. A design that forgets the carry-in of one, or that reports a true borrow rather than its inverse, shows a difference off by one or a flipped bit 4.

Arithmetic modes are checked for zero upper bits. This catches multiply-column residue leaking into bits 7:5.

// File: rtl/xw_pkg.sv
// Package: shared operand width and operation codes for the crosswise unit.
// Assumes: unsigned operands only; no state anywhere in the unit.
package xw_pkg;

    localparam int XW_WIDTH = 4;

    // Operation select codes; both 00 and 11 select multiply (R1)
    typedef enum logic [1:0] {
        XW_MUL  = 2'b00,
        XW_ADD  = 2'b01,
        XW_SUB  = 2'b10,
        XW_MULX = 2'b11
    } xw_op_e;

endpackage

// File: rtl/xw_pp_array.sv
// Module: partial-product AND array.
// Forms one AND term for every pairing of an A bit with a B bit.
// Assumes: W x W terms, where pp[i][j] carries weight i+j.
module xw_pp_array #(
    parameter int W = 4
) (
    input  logic [W-1:0]        a_in,
    input  logic [W-1:0]        b_in,
    output logic [W-1:0][W-1:0] pp
);

    // One AND gate per (A bit, B bit) pair
    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_col
            assign pp[i][j] = a_in[i] & b_in[j];
        end
    end

endmodule

// File: rtl/xw_column.sv
// Module: one weight column of the crosswise adder tree.
// Adds up to NT single-bit terms and the carry word from the column below.
// Emits the column's result bit and a carry word for the column above.
// Assumes: CW is wide enough that the column total never exceeds 2**(CW+1)-1.
module xw_column #(
    parameter int NT = 4,
    parameter int CW = 3
) (
    input  logic [NT-1:0] terms,
    input  logic [CW-1:0] cin,
    output logic          sum_bit,
    output logic [CW-1:0] cout
);

    logic [CW:0] total;

    // Sum the incoming carry word and every term of this column
    always_comb begin
        total = {1'b0, cin};
        for (int i = 0; i < NT; i++) begin
            total = total + {{CW{1'b0}}, terms[i]};
        end
    end

    assign sum_bit = total[0];
    assign cout    = total[CW:1];

endmodule

// File: rtl/xw_arith4.sv
// Module: crosswise multiply / add / subtract unit (top).
// One column adder tree of 2W-1 columns forms the product.
// Its lowest W columns can take operand bits instead of partial products,
// which turns them into the add/subtract path.
// Assumes: purely combinational; unsigned operands; W >= 2.
module xw_arith4
    import xw_pkg::*;
#(
    parameter int W = XW_WIDTH
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [1:0]     op_sel,
    output logic [2*W-1:0] result,
    output logic           carry_flag
);

    localparam int NCOL = 2 * W - 1;
    localparam int CW   = $clog2(W + 1);

    xw_op_e                op;
    logic                  is_arith;
    logic                  is_sub;
    logic [W-1:0]          b_adj;
    logic [W-1:0][W-1:0]   pp;
    logic [W-1:0]          mul_terms [NCOL];
    logic [W-1:0]          col_terms [NCOL];
    logic [CW-1:0]         col_cin   [NCOL];
    logic [CW-1:0]         col_cout  [NCOL];
    logic [NCOL-1:0]       col_sum;

    // Decode the operation select into path controls
    always_comb begin
        op       = xw_op_e'(op_sel);
        is_sub   = (op == XW_SUB);
        is_arith = (op == XW_ADD) || (op == XW_SUB);
    end

    // Invert B for subtraction (two's complement with carry-in of one)
    assign b_adj = opnd_b ^ {W{is_sub}};

    xw_pp_array #(.W(W)) u_pp (
        .a_in (opnd_a),
        .b_in (opnd_b),
        .pp   (pp)
    );

    // Gather terms per weight column and build the column chain
    for (genvar k = 0; k < NCOL; k++) begin : g_colsel
        for (genvar i = 0; i < W; i++) begin : g_term
            if ((k - i) >= 0 && (k - i) < W) begin : g_on
                assign mul_terms[k][i] = pp[i][k-i];
            end else begin : g_off
                assign mul_terms[k][i] = 1'b0;
            end
        end

        if (k < W) begin : g_shared
            // Branch point: lower columns serve both paths
            assign col_terms[k] = is_arith
                ? {{(W-2){1'b0}}, b_adj[k], opnd_a[k]}
                : mul_terms[k];
        end else begin : g_upper
            assign col_terms[k] = mul_terms[k];
        end

        if (k == 0) begin : g_first
            assign col_cin[k] = {{(CW-1){1'b0}}, is_sub};
        end else begin : g_chain
            assign col_cin[k] = col_cout[k-1];
        end

        xw_column #(.NT(W), .CW(CW)) u_col (
            .terms   (col_terms[k]),
            .cin     (col_cin[k]),
            .sum_bit (col_sum[k]),
            .cout    (col_cout[k])
        );
    end

    // Pick product bits or the zero-extended {carry, sum} word
    always_comb begin
        if (is_arith) begin
            result        = '0;
            result[W-1:0] = col_sum[W-1:0];
            result[W]     = col_cout[W-1][0];
            carry_flag    = col_cout[W-1][0];
        end else begin
            result        = {col_cout[NCOL-1][0], col_sum};
            carry_flag    = 1'b0;
        end
    end

    // Outputs checked against plain arithmetic whenever the inputs are known
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (!is_arith) begin
                a_r2_product: assert (result == ((2*W)'(opnd_a) * (2*W)'(opnd_b)));
                a_r3_bit0_direct: assert (result[0] == (opnd_a[0] & opnd_b[0]));
                a_r4_flag_low: assert (carry_flag == 1'b0);
                a_r9_top_carry_fits: assert (col_cout[NCOL-1][CW-1:1] == '0);
            end
            if (op == XW_ADD) begin
                a_r5_sum: assert (result[W:0] == ({1'b0, opnd_a} + {1'b0, opnd_b}));
            end
            if (op == XW_SUB) begin
                a_r6_diff: assert (result[W:0] ==
                    ({1'b0, opnd_a} + {1'b0, ~opnd_b} + (W+1)'(1)));
            end
            if (is_arith) begin
                a_r7_upper_zero: assert (result[2*W-1:W+1] == '0);
                a_r7_flag_match: assert (carry_flag == result[W]);
            end
            a_r1_decode: assert (is_arith == (op_sel == 2'b01 || op_sel == 2'b10));
        end
    end

endmodule

// File: tb/xw_arith4_test.sv
// Bench: behavioural reference with integers, compared once per clock.
// The unit is combinational; the clock only paces stimulus and sampling.
module xw_arith4_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic [1:0] op = '0;
    logic [7:0] res;
    logic       flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xw_arith4 uut (
        .opnd_a     (a),
        .opnd_b     (b),
        .op_sel     (op),
        .result     (res),
        .carry_flag (flag)
    );

    // Compare one observed value with the reference value
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%0d b=%0d op=%0d actual=%0d expected=%0d",
                     tag, a, b, op, act, exp);
        end
    endtask

    // Behavioural reference for the full result bus
    function automatic int ref_result(int ia, int ib, int iop);
        int r;
        if (iop == 1) r = ia + ib;
        else if (iop == 2) r = (ia >= ib) ? (16 + ia - ib) : (ia - ib + 16);
        else r = ia * ib;
        if (iop == 2) r = (r & 15) | ((ia >= ib) ? 16 : 0);
        return r;
    endfunction

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset phase: zero inputs must give zero outputs
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset result", int'(res), 0);
        check("R4 reset flag", int'(flag), 0);
        rst_n = 1'b1;

        // Full sweep of every select code and operand pair
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    @(posedge clk);
                    #1;
                    a  = 4'(x);
                    b  = 4'(y);
                    op = 2'(m);
                    // R8: sampled in the same cycle the inputs changed
                    #1;
                    if (m == 0 || m == 3) begin
                        check("R1 R2 product", int'(res), x * y);
                        check("R4 flag zero", int'(flag), 0);
                        if (x == 15 && y == 15)
                            check("R9 top carry", int'(res[7]), 1);
                        if (y == 1)
                            check("R3 bit0", int'(res[0]), x & 1);
                    end else if (m == 1) begin
                        check("R1 R5 sum", int'(res), ref_result(x, y, 1));
                        check("R7 flag add", int'(flag), (x + y) > 15 ? 1 : 0);
                    end else begin
                        check("R1 R6 diff", int'(res), ref_result(x, y, 2));
                        check("R7 flag sub", int'(flag), (x >= y) ? 1 : 0);
                        check("R7 upper zero", int'(res[7:5]), 0);
                    end
                end
            end
        end

        // R8: switch select only, operands held, within one cycle
        @(posedge clk);
        #1;
        a = 4'd9; b = 4'd7; op = 2'b01;
        #1;
        check("R8 same cycle add", int'(res), 16);
        op = 2'b00;
        #1;
        check("R8 same cycle mul", int'(res), 63);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule